// File: doc/BRIEF.md
# Multicycle Load/Store Datapath

This block is the data side of a small multicycle processor that executes five
instruction classes: register-register arithmetic and logic, OR with a 16-bit
immediate, word load, word store and branch-on-equal. It does not sequence
itself. An external controller drives one enable or select per step, and each
step moves data into a holding register. The holding registers are the program
counter, the instruction register, two operand registers, the ALU result, the
memory data register and the equality flag. Every transfer takes effect on the
clock edge at which its step ends, so the longest path is one step and never a
whole instruction.

The block contains a 32-entry register file, a word-addressed instruction
memory and a word-addressed data memory. The instruction memory is filled
through a valid/ready load port. A word is accepted on a rising edge where both
`il_valid` and `il_ready` are high. `il_ready` drops in any cycle where the
fetch step reads the instruction memory, and a word offered in such a cycle is
held off until ready returns. The controller reads back only the opcode of the
current instruction and the equality flag.

Top module: `mc_datapath`

## Requirements
- R1: After reset, PC, IR, A, B, S, M and E all hold zero, so `opcode` and `eq_flag` are 0 and the first fetch reads instruction word 0.
- R2: With `ir_we` high, IR loads the instruction word at word index PC[7:2]. `opcode` always shows IR[31:26].
- R3: With `a_we`/`b_we` high, A and B load the register file entries named by IR[25:21] (rs) and IR[20:16] (rt) in the same cycle. With `e_we` high, E loads 1 when those two entries are equal and 0 otherwise, and `eq_flag` shows E.
- R4: With `s_we` high, S loads A op X. `alu_op` picks the operation: 0 add, 1 subtract, 2 by function field, 3 OR. `src2_sel` picks X: 0 B, 1 sign-extended IR[15:0], 2 zero-extended IR[15:0], 3 B.
- R5: In function mode, IR[5:0] selects the operation: 0x20 or 0x21 add, 0x22 or 0x23 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. Any other value gives 0.
- R6: With `m_we` high, M loads the data memory word at index S[7:2]. With `dmem_we` high, B is written to that word.
- R7: With `rf_we` high, the register file writes M (`rf_from_m`=1) or S (`rf_from_m`=0) to rd = IR[15:11] (`rf_dst_rd`=1) or to rt (`rf_dst_rd`=0).
- R8: Register 0 reads as zero, and writes to it are discarded.
- R9: With `pc_we` high and `pc_br` low, PC becomes PC+4. With both high, PC becomes PC+4 plus the sign-extended IR[15:0] shifted left by two if E is 1, and PC+4 otherwise.
- R10: Each holding register keeps its value in any cycle where its own enable is low.
- R11: `il_ready` is low exactly when `ir_we` is high. A word is written to index `il_addr` only on an edge where `il_valid` and `il_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| il_valid | input | 1 | Instruction load word offered |
| il_ready | output | 1 | Instruction memory can accept a load word |
| il_addr | input | IMEM_AW | Word index of the load word |
| il_data | input | 32 | Load word |
| ir_we | input | 1 | Fetch step: load IR |
| a_we | input | 1 | Load A from rs |
| b_we | input | 1 | Load B from rt |
| e_we | input | 1 | Load E with rs==rt |
| alu_op | input | 2 | ALU operation select |
| src2_sel | input | 2 | Second ALU operand select |
| s_we | input | 1 | Load S from the ALU |
| m_we | input | 1 | Load M from data memory |
| dmem_we | input | 1 | Write B to data memory |
| rf_we | input | 1 | Register file write |
| rf_dst_rd | input | 1 | Destination is rd (1) or rt (0) |
| rf_from_m | input | 1 | Write data is M (1) or S (0) |
| pc_we | input | 1 | Update PC |
| pc_br | input | 1 | PC update is a conditional branch on E |
| opcode | output | 6 | IR[31:26] |
| eq_flag | output | 1 | Equality flag E |

## Verification
Each step's result becomes visible at the ports one register after its enable is sampled. The opcode changes on the edge that ends the fetch step, and the equality flag changes on the edge that ends the decode step. A register-file or data-memory write shows up only when a later decode compares that entry through E, and a branch outcome shows up in the opcode of the next fetch. The driver pushes an expectation once the edge that completes a step has passed. The monitor compares it at the next falling edge, so no value is sampled before the register that produces it has been clocked.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int OP_W   = 6;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_FN  = 2'd2,
    ALU_OR  = 2'd3
  } alu_sel_e;

  typedef enum logic [1:0] {
    SRC_B    = 2'd0,
    SRC_SEXT = 2'd1,
    SRC_ZEXT = 2'd2,
    SRC_B2   = 2'd3
  } src_sel_e;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;
endpackage

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);
  localparam int N = 1 << AW;

  logic [DW-1:0] regs [0:N-1];

  // entry 0 is never written; reads of it return zero (R8)
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  always_comb begin
    rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    rd_b = (ra_b == '0) ? '0 : regs[ra_b];
  end
endmodule

// File: rtl/mc_mem.sv
`timescale 1ns/1ps
module mc_mem #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] words [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    sel,
  input  logic [5:0]    funct,
  output logic [DW-1:0] y
);
  logic [DW-1:0] fn_y;

  always_comb begin
    unique case (funct)
      FN_ADD, FN_ADDU: fn_y = a + b;
      FN_SUB, FN_SUBU: fn_y = a - b;
      FN_AND:          fn_y = a & b;
      FN_OR:           fn_y = a | b;
      FN_SLT:          fn_y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default:         fn_y = '0;
    endcase
  end

  always_comb begin
    unique case (alu_sel_e'(sel))
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_FN:  y = fn_y;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
  import mc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               il_valid,
  output logic               il_ready,
  input  logic [IMEM_AW-1:0] il_addr,
  input  logic [XLEN-1:0]    il_data,
  input  logic               ir_we,
  input  logic               a_we,
  input  logic               b_we,
  input  logic               e_we,
  input  logic [1:0]         alu_op,
  input  logic [1:0]         src2_sel,
  input  logic               s_we,
  input  logic               m_we,
  input  logic               dmem_we,
  input  logic               rf_we,
  input  logic               rf_dst_rd,
  input  logic               rf_from_m,
  input  logic               pc_we,
  input  logic               pc_br,
  output logic [OP_W-1:0]    opcode,
  output logic               eq_flag
);
  localparam int IMM_W = 16;

  // holding registers
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, s_q, m_q;
  logic            e_q;

  // instruction fields
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx;
  logic [IMM_W-1:0]  imm16;
  logic [XLEN-1:0]   imm_sx, imm_zx, br_off;

  assign rs_idx = ir_q[25:21];
  assign rt_idx = ir_q[20:16];
  assign rd_idx = ir_q[15:11];
  assign imm16  = ir_q[IMM_W-1:0];
  assign imm_sx = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
  assign imm_zx = {{(XLEN-IMM_W){1'b0}}, imm16};
  assign br_off = imm_sx << 2;

  // instruction memory with load port
  logic            il_fire;
  logic [XLEN-1:0] imem_rdata;

  assign il_ready = ~ir_we;
  assign il_fire  = il_valid & il_ready;

  mc_mem #(.DW(XLEN), .AW(IMEM_AW)) u_imem (
    .clk   (clk),
    .we    (il_fire),
    .waddr (il_addr),
    .wdata (il_data),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (imem_rdata)
  );

  // register file
  logic [XLEN-1:0]   rf_rd_a, rf_rd_b, wb_data;
  logic [REG_AW-1:0] wb_idx;

  assign wb_data = rf_from_m ? m_q : s_q;
  assign wb_idx  = rf_dst_rd ? rd_idx : rt_idx;

  mc_regfile #(.DW(XLEN), .AW(REG_AW)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .wa   (wb_idx),
    .wd   (wb_data),
    .ra_a (rs_idx),
    .ra_b (rt_idx),
    .rd_a (rf_rd_a),
    .rd_b (rf_rd_b)
  );

  // execute
  logic [XLEN-1:0] src2, alu_y;

  always_comb begin
    unique case (src_sel_e'(src2_sel))
      SRC_SEXT: src2 = imm_sx;
      SRC_ZEXT: src2 = imm_zx;
      default:  src2 = b_q;
    endcase
  end

  mc_alu #(.DW(XLEN)) u_alu (
    .a     (a_q),
    .b     (src2),
    .sel   (alu_op),
    .funct (ir_q[5:0]),
    .y     (alu_y)
  );

  // data memory
  logic [XLEN-1:0] dmem_rdata;

  mc_mem #(.DW(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .waddr (s_q[DMEM_AW+1:2]),
    .wdata (b_q),
    .raddr (s_q[DMEM_AW+1:2]),
    .rdata (dmem_rdata)
  );

  // next program counter
  logic [XLEN-1:0] pc_plus4, pc_next;

  assign pc_plus4 = pc_q + XLEN'(4);
  assign pc_next  = (pc_br && e_q) ? (pc_plus4 + br_off) : pc_plus4;

  // each holding register has its own enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      s_q  <= '0;
      m_q  <= '0;
      e_q  <= 1'b0;
    end else begin
      if (pc_we) pc_q <= pc_next;
      if (ir_we) ir_q <= imem_rdata;
      if (a_we)  a_q  <= rf_rd_a;
      if (b_we)  b_q  <= rf_rd_b;
      if (s_we)  s_q  <= alu_y;
      if (m_we)  m_q  <= dmem_rdata;
      if (e_we)  e_q  <= (rf_rd_a == rf_rd_b);
    end
  end

  assign opcode  = ir_q[31:26];
  assign eq_flag = e_q;
endmodule

// File: rtl/mc_datapath_chk.sv
`timescale 1ns/1ps
module mc_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ir_we,
  input logic        e_we,
  input logic        pc_we,
  input logic        pc_br,
  input logic        il_ready,
  input logic [31:0] ir_q,
  input logic        e_q,
  input logic [31:0] pc_q,
  input logic [31:0] rf_rd_a,
  input logic [31:0] rf_rd_b,
  input logic [4:0]  rs_idx
);
  // R1
  pc_reset_chk: assert property (@(posedge clk) !rst_n |=> (pc_q == 32'd0));

  // R10
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir_q));

  // R10
  e_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !e_we |=> $stable(e_q));

  // R3
  eq_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_we |=> (e_q == ($past(rf_rd_a) == $past(rf_rd_b))));

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == 5'd0) |-> (rf_rd_a == 32'd0));

  // R9
  pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !pc_br) |=> (pc_q == $past(pc_q) + 32'd4));

  // R9
  pc_untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_br && !e_q) |=> (pc_q == $past(pc_q) + 32'd4));

  // R11
  load_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |-> !il_ready);
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ir_we    (ir_we),
  .e_we     (e_we),
  .pc_we    (pc_we),
  .pc_br    (pc_br),
  .il_ready (il_ready),
  .ir_q     (ir_q),
  .e_q      (e_q),
  .pc_q     (pc_q),
  .rf_rd_a  (rf_rd_a),
  .rf_rd_b  (rf_rd_b),
  .rs_idx   (rs_idx)
);

// File: tb/mc_datapath_tb_top.sv
`timescale 1ns/1ps
module mc_datapath_tb_top;
  localparam int HALF   = 10;
  localparam int NPROG  = 27;
  localparam int NSTEPS = 30;
  localparam logic [5:0] OP_R = 6'h00, OP_ORI = 6'h0D, OP_LW = 6'h23,
                         OP_SW = 6'h2B, OP_BEQ = 6'h04;
  localparam logic [1:0] A_ADD = 2'd0, A_FN = 2'd2, A_OR = 2'd3;
  localparam logic [1:0] S_B = 2'd0, S_SX = 2'd1, S_ZX = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic il_valid = 0, il_ready;
  logic [5:0] il_addr = '0;
  logic [31:0] il_data = '0;
  logic ir_we = 0, a_we = 0, b_we = 0, e_we = 0, s_we = 0, m_we = 0, dmem_we = 0;
  logic rf_we = 0, rf_dst_rd = 0, rf_from_m = 0, pc_we = 0, pc_br = 0;
  logic [1:0] alu_op = '0, src2_sel = '0;
  logic [5:0] opcode;
  logic eq_flag;

  always #HALF clk = ~clk;

  mc_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .il_valid(il_valid), .il_ready(il_ready),
    .il_addr(il_addr), .il_data(il_data), .ir_we(ir_we), .a_we(a_we),
    .b_we(b_we), .e_we(e_we), .alu_op(alu_op), .src2_sel(src2_sel),
    .s_we(s_we), .m_we(m_we), .dmem_we(dmem_we), .rf_we(rf_we),
    .rf_dst_rd(rf_dst_rd), .rf_from_m(rf_from_m), .pc_we(pc_we),
    .pc_br(pc_br), .opcode(opcode), .eq_flag(eq_flag)
  );

  typedef struct {
    logic [5:0] op;
    logic       chk_eq;
    logic       eq;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;
  int n_chk = 0, n_fail = 0;
  logic [31:0] prog [0:NPROG-1];
  logic [31:0] mrf [0:31];
  logic [31:0] mdm [0:63];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      check(cur.tag, {26'd0, opcode}, {26'd0, cur.op});
      if (cur.chk_eq) check(cur.tag, {31'd0, eq_flag}, {31'd0, cur.eq});
    end
  end

  task automatic push_exp(input logic [5:0] op, input logic ce, input logic eq, input string tag);
    exp_t e;
    e.op = op; e.chk_eq = ce; e.eq = eq; e.tag = tag;
    sb_q.push_back(e);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    ir_we = 0; a_we = 0; b_we = 0; e_we = 0; s_we = 0; m_we = 0; dmem_we = 0;
    rf_we = 0; rf_dst_rd = 0; rf_from_m = 0; pc_we = 0; pc_br = 0;
    alu_op = '0; src2_sel = '0;
  endtask

  task automatic do_fetch();  ir_we = 1; cyc(); clr(); endtask
  task automatic do_decode(); a_we = 1; b_we = 1; e_we = 1; cyc(); clr(); endtask
  task automatic do_exec(input logic [1:0] op, input logic [1:0] src);
    alu_op = op; src2_sel = src; s_we = 1; cyc(); clr();
  endtask
  task automatic do_mread();  m_we = 1; cyc(); clr(); endtask
  task automatic do_mwrite(); dmem_we = 1; cyc(); clr(); endtask
  task automatic do_wb(input logic to_rd, input logic from_m);
    rf_we = 1; rf_dst_rd = to_rd; rf_from_m = from_m; cyc(); clr();
  endtask
  task automatic do_pc(input logic br); pc_we = 1; pc_br = br; cyc(); clr(); endtask

  function automatic logic [31:0] ri(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] ii(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] model_fn(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20, 6'h21: return a + b;
      6'h22, 6'h23: return a - b;
      6'h24:        return a & b;
      6'h25:        return a | b;
      6'h2A:        return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default:      return 32'd0;
    endcase
  endfunction

  initial begin
    #(2 * HALF * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int idx;
    logic [5:0] hold_op;
    logic hold_eq;

    prog[0]  = ii(OP_ORI, 0, 1, 16'h0005);
    prog[1]  = ii(OP_ORI, 0, 2, 16'h0003);
    prog[2]  = ri(1, 2, 3, 6'h20);
    prog[3]  = ii(OP_ORI, 0, 4, 16'h0008);
    prog[4]  = ii(OP_BEQ, 3, 4, 16'h0001);
    prog[5]  = ii(OP_ORI, 0, 7, 16'hFFFF);
    prog[6]  = ri(1, 2, 5, 6'h22);
    prog[7]  = ii(OP_ORI, 0, 6, 16'h0002);
    prog[8]  = ii(OP_BEQ, 5, 6, 16'h0000);
    prog[9]  = ii(OP_BEQ, 5, 1, 16'h0001);
    prog[10] = ii(OP_ORI, 0, 8, 16'h8000);
    prog[11] = ii(OP_SW, 0, 8, 16'h0008);
    prog[12] = ii(OP_LW, 0, 9, 16'h0008);
    prog[13] = ii(OP_BEQ, 9, 8, 16'h0000);
    prog[14] = ii(OP_ORI, 0, 10, 16'h00F0);
    prog[15] = ri(10, 1, 11, 6'h25);
    prog[16] = ii(OP_ORI, 0, 12, 16'h00F5);
    prog[17] = ii(OP_BEQ, 11, 12, 16'h0000);
    prog[18] = ri(2, 1, 13, 6'h2A);
    prog[19] = ii(OP_ORI, 0, 14, 16'h0001);
    prog[20] = ii(OP_BEQ, 13, 14, 16'h0000);
    prog[21] = ii(OP_ORI, 0, 0, 16'h0007);
    prog[22] = ii(OP_BEQ, 0, 4, 16'h0000);
    prog[23] = ii(OP_ORI, 0, 16, 16'h000C);
    prog[24] = ii(OP_LW, 16, 15, 16'hFFFC);
    prog[25] = ii(OP_BEQ, 15, 8, 16'h0000);
    prog[26] = ii(OP_BEQ, 0, 0, 16'hFFFD);
    for (int i = 0; i < 32; i++) mrf[i] = 32'd0;
    for (int i = 0; i < 64; i++) mdm[i] = 32'd0;

    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 opcode after reset", {26'd0, opcode}, 32'd0);
    check("R1 eq_flag after reset", {31'd0, eq_flag}, 32'd0);
    // R11 ready follows the fetch enable
    check("R11 ready while idle", {31'd0, il_ready}, 32'd1);
    ir_we = 1;
    #1;
    check("R11 ready during fetch", {31'd0, il_ready}, 32'd0);
    ir_we = 0;
    #1;

    for (int i = 0; i < NPROG; i++) begin
      il_valid = 1; il_addr = 6'(i); il_data = prog[i];
      cyc();
    end
    il_valid = 0;

    idx = 0;
    for (int n = 0; n < NSTEPS; n++) begin
      logic [31:0] ins;
      logic [5:0] op;
      int rs, rt, rd, off;
      logic eq;
      ins = prog[idx];
      op = ins[31:26];
      rs = int'(ins[25:21]);
      rt = int'(ins[20:16]);
      rd = int'(ins[15:11]);
      off = $signed(ins[15:0]);

      do_fetch();
      push_exp(op, 1'b0, 1'b0, "R2 R9 fetched opcode");
      do_decode();
      eq = (mrf[rs] == mrf[rt]);
      push_exp(op, 1'b1, eq, "R3 R4 R5 R6 R7 R8 decode compare");

      case (op)
        OP_R: begin
          do_exec(A_FN, S_B);
          do_wb(1'b1, 1'b0);
          if (rd != 0) mrf[rd] = model_fn(ins[5:0], mrf[rs], mrf[rt]);
        end
        OP_ORI: begin
          do_exec(A_OR, S_ZX);
          do_wb(1'b0, 1'b0);
          if (rt != 0) mrf[rt] = mrf[rs] | {16'd0, ins[15:0]};
        end
        OP_LW: begin
          do_exec(A_ADD, S_SX);
          do_mread();
          do_wb(1'b0, 1'b1);
          if (rt != 0) mrf[rt] = mdm[6'((mrf[rs] + 32'(off)) >> 2)];
        end
        OP_SW: begin
          do_exec(A_ADD, S_SX);
          do_mwrite();
          mdm[6'((mrf[rs] + 32'(off)) >> 2)] = mrf[rt];
        end
        default: ;
      endcase

      do_pc(op == OP_BEQ);
      if (op == OP_BEQ && eq) idx = idx + 1 + off;
      else idx = idx + 1;
    end

    // R10 hold: other enables toggle, IR and E must not move
    hold_op = opcode;
    hold_eq = eq_flag;
    a_we = 1; b_we = 1; s_we = 1; m_we = 1;
    repeat (4) cyc();
    clr();
    push_exp(hold_op, 1'b1, hold_eq, "R10 hold with enables low");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule